// File: doc/BRIEF.md
# Programmable-Polynomial CRC / Pseudo-Random Sequence Shift Register

This block is a shift register with programmable feedback taps. It computes a cyclic redundancy check over a serial bit stream, or it runs as a pseudo-random sequence generator. Software loads a tap mask and a starting value over a small register bus and then sets the enable bit. After that, each accepted serial bit moves the register one step. The bit leaving the top of the register appears on the serial output. A second output compares the register with the seed/residue register, and this comparison can drive downstream logic.

The register itself cannot be written directly. It is loaded as a side effect of writing the seed while the block is idle. A kill input forces the seed back into the register on every clock for as long as the input is high. When the block is idle, reading the register's address copies the register into the seed/residue register, and software then reads the CRC residue from there.

The serial input is a valid/ready stream. A bit is consumed on a clock where `sin_valid` and `sin_ready` are both high. `sin_ready` is high only while the block is enabled and kill is low, so the sender must hold its bit until ready returns. There is no back-pressure on the output side: `sout_bit` is always the bit that the next accepted input will push out.

Top module: `lfsr_crc_prs`

## Requirements
- R1: After reset, the shift register, tap mask, seed/residue register, enable bit and mode bit are all zero, and `sin_ready` is low.
- R2: While the block is disabled, a write to the seed address (`bus_sel`=2) loads the written value into both the seed/residue register and the shift register in the same clock.
- R3: Each accepted step computes f = MSB XOR `sin_bit`, shifts the register left by one with 0 entering bit 0, then XORs f into every bit whose tap mask bit is set. Tap bit 0 corresponds to the x^0 term.
- R4: When `sin_bit` is held at 0, the steps produce the free-running pseudo-random sequence set by the tap mask.
- R5: `sout_bit` equals the register's MSB before the step that shifts it out.
- R6: While `kill` is high, the seed/residue value is loaded into the register on every rising clock edge, and `sin_ready` is low.
- R7: While the block is disabled, a read of the register address (`bus_sel`=0) returns 00h on `bus_rdata` and copies the register into the seed/residue register at that clock edge.
- R8: The tap mask (`bus_sel`=1) is write-only and reads as 00h. Writes to it while the block is enabled are ignored.
- R9: While the block is enabled, a seed write changes only the compare operand. The shift register is not affected.
- R10: `aux_out` is (register == seed) when the mode bit is 0, and (register < seed, unsigned) when the mode bit is 1.
- R11: While the block is disabled and `kill` is low, the register holds its value, and `sin_ready` is low whatever `sin_valid` does.
- R12: The control address (`bus_sel`=3) holds the enable bit in bit 0 and the mode bit in bit 1. It reads back as written, with all other bits reading 0. The seed address reads back the seed/residue register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Register select: 0 shift reg, 1 tap mask, 2 seed/residue, 3 control |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_rd | input | 1 | Read strobe for one clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| kill | input | 1 | Seed reload request, applied on every clock while high |
| sin_valid | input | 1 | Serial input bit is valid |
| sin_ready | output | 1 | Block accepts a serial bit this clock |
| sin_bit | input | 1 | Serial data bit |
| sout_bit | output | 1 | Register MSB, shifted out by the next accepted step |
| aux_out | output | 1 | Result of comparing the register with the seed/residue register |

## Verification
Some behaviour is checked by assertions on every cycle. The register holds while idle, the kill reload takes place, the idle seed write loads the register, and the tap mask stays stable while the block is enabled. The residue copy on an idle register read and the 00h read data for that address are also checked at every clock. Other behaviour can only be shown by the bench's scenarios. These are the values of the CRC and pseudo-random sequences over many steps, the serial output bit at each step, the ordering of the two compare modes, and the fact that a tap write while enabled leaves the following steps unchanged.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  typedef enum logic [1:0] {
    SEL_SHIFT = 2'd0,
    SEL_TAPS  = 2'd1,
    SEL_SEED  = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    CMP_EQ = 1'b0,
    CMP_LT = 1'b1
  } cmp_mode_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
endpackage

// File: rtl/lfsr_regs.sv
module lfsr_regs
  import lfsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_sel,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] shift_i,
  output logic [W-1:0] taps_o,
  output logic [W-1:0] seed_o,
  output logic         en_o,
  output cmp_mode_e    mode_o,
  output logic         seed_ld_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] taps_q, seed_q;
  logic         en_q;
  cmp_mode_e    mode_q;
  logic         wr_taps, wr_seed, wr_ctrl, rd_shift_idle;

  assign wr_taps       = bus_wr && (bus_sel == SEL_TAPS) && !en_q;
  assign wr_seed       = bus_wr && (bus_sel == SEL_SEED);
  assign wr_ctrl       = bus_wr && (bus_sel == SEL_CTRL);
  assign rd_shift_idle = bus_rd && (bus_sel == SEL_SHIFT) && !en_q;
  assign seed_ld_o     = wr_seed && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else if (wr_taps) taps_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seed_q <= '0;
    else if (wr_seed) seed_q <= bus_wdata;
    else if (rd_shift_idle) seed_q <= shift_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= CMP_EQ;
    end else if (wr_ctrl) begin
      en_q   <= bus_wdata[CTRL_EN_BIT];
      mode_q <= cmp_mode_e'(bus_wdata[CTRL_MODE_BIT]);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (bus_sel)
      SEL_SEED: rdata_o = seed_q;
      SEL_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = en_q;
        rdata_o[CTRL_MODE_BIT] = mode_q;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign taps_o = taps_q;
  assign seed_o = seed_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;

  // R8
  taps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(taps_q));

  // R7
  residue_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_sel == SEL_SHIFT && !en_q) |=> (seed_q == $past(shift_i)));

  // R7
  shift_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SEL_SHIFT) |-> (rdata_o == '0));
endmodule

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         kill_i,
  input  logic         seed_ld_i,
  input  logic [W-1:0] seed_wdata_i,
  input  logic [W-1:0] seed_q_i,
  input  logic [W-1:0] taps_i,
  input  logic         step_valid_i,
  input  logic         step_bit_i,
  output logic         step_ready_o,
  output logic         sout_o,
  output logic [W-1:0] shift_o
);
  logic [W-1:0] shift_q, shift_nxt;
  logic         fb, step;

  assign step_ready_o = en_i && !kill_i;
  assign step         = step_ready_o && step_valid_i;
  assign fb           = shift_q[W-1] ^ step_bit_i;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign shift_nxt[i] = fb & taps_i[i];
    end else begin : g_up
      assign shift_nxt[i] = shift_q[i-1] ^ (fb & taps_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else if (kill_i) shift_q <= seed_q_i;
    else if (seed_ld_i) shift_q <= seed_wdata_i;
    else if (step) shift_q <= shift_nxt;
  end

  assign sout_o  = shift_q[W-1];
  assign shift_o = shift_q;

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !kill_i && !seed_ld_i) |=> $stable(shift_q));

  // R6
  kill_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (shift_q == $past(seed_q_i)));

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ld_i && !kill_i) |=> (shift_q == $past(seed_wdata_i)));

  // R6
  kill_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |-> !step_ready_o);
endmodule

// File: rtl/lfsr_cmp.sv
module lfsr_cmp
  import lfsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] shift_i,
  input  logic [W-1:0] seed_i,
  input  cmp_mode_e    mode_i,
  output logic         aux_o
);
  always_comb begin
    case (mode_i)
      CMP_LT:  aux_o = (shift_i < seed_i);
      default: aux_o = (shift_i == seed_i);
    endcase
  end
endmodule

// File: rtl/lfsr_crc_prs.sv
module lfsr_crc_prs
  import lfsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_sel,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         kill,
  input  logic         sin_valid,
  output logic         sin_ready,
  input  logic         sin_bit,
  output logic         sout_bit,
  output logic         aux_out
);
  logic [W-1:0] taps, seed, shift;
  logic         en, seed_ld;
  cmp_mode_e    mode;

  lfsr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .shift_i(shift),
    .taps_o(taps), .seed_o(seed), .en_o(en), .mode_o(mode),
    .seed_ld_o(seed_ld), .rdata_o(bus_rdata)
  );

  lfsr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .en_i(en), .kill_i(kill),
    .seed_ld_i(seed_ld), .seed_wdata_i(bus_wdata), .seed_q_i(seed),
    .taps_i(taps), .step_valid_i(sin_valid), .step_bit_i(sin_bit),
    .step_ready_o(sin_ready), .sout_o(sout_bit), .shift_o(shift)
  );

  lfsr_cmp #(.W(W)) u_cmp (
    .shift_i(shift), .seed_i(seed), .mode_i(mode), .aux_o(aux_out)
  );

  // R9
  live_seed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !kill && bus_wr && bus_sel == SEL_SEED && !(sin_valid && sin_ready))
      |=> $stable(shift));
endmodule

// File: tb/test_lfsr_crc_prs.sv
module test_lfsr_crc_prs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       kill = 1'b0, sin_valid = 1'b0, sin_bit = 1'b0;
  logic       sin_ready, sout_bit, aux_out;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_shift = 8'h00, m_seed = 8'h00, m_taps = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_crc_prs i_lfsr_crc_prs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kill(kill), .sin_valid(sin_valid), .sin_ready(sin_ready),
    .sin_bit(sin_bit), .sout_bit(sout_bit), .aux_out(aux_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_step(input logic [7:0] s, input logic [7:0] t, input logic b);
    logic f;
    f = s[7] ^ b;
    return {s[6:0], 1'b0} ^ (f ? t : 8'h00);
  endfunction

  task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Disabled-only: read the shift address, then read the copied residue.
  task automatic peek_shift(input string req);
    @(negedge clk);
    bus_sel = 2'd0; bus_rd = 1'b1;
    #1 check("R7 shift read zero", bus_rdata, 8'h00);
    @(negedge clk);
    bus_rd = 1'b0; bus_sel = 2'd2;
    #1 check(req, bus_rdata, m_shift);
    m_seed = m_shift;
  endtask

  task automatic step(input logic b, input string req);
    @(negedge clk);
    sin_valid = 1'b1; sin_bit = b;
    #1 check("R12 ready while enabled", {7'd0, sin_ready}, 8'h01);
    check(req, {7'd0, sout_bit}, {7'd0, m_shift[7]});
    @(negedge clk);
    sin_valid = 1'b0; sin_bit = 1'b0;
    m_shift = model_step(m_shift, m_taps, b);
  endtask

  task automatic t_reset();
    #1 check("R1 ready low", {7'd0, sin_ready}, 8'h00);
    check("R1 sout zero", {7'd0, sout_bit}, 8'h00);
    bus_sel = 2'd2; #1 check("R1 seed zero", bus_rdata, 8'h00);
    bus_sel = 2'd3; #1 check("R1 control zero", bus_rdata, 8'h00);
    check("R1 aux eq of zeros", {7'd0, aux_out}, 8'h01);
    peek_shift("R1 shift zero");
  endtask

  task automatic t_seed_load();
    bus_write(2'd1, 8'h07); m_taps = 8'h07;
    bus_write(2'd2, 8'hA5); m_seed = 8'hA5; m_shift = 8'hA5;
    peek_shift("R2 idle seed write loads shift");
  endtask

  task automatic t_crc();
    logic [15:0] msg = 16'h31C4;
    bus_write(2'd3, 8'h01);
    for (int i = 15; i >= 0; i--) step(msg[i], "R5 sout is pre-shift MSB");
    bus_write(2'd3, 8'h00);
    peek_shift("R3 crc residue");
  endtask

  task automatic t_prs();
    bus_write(2'd1, 8'hB8); m_taps = 8'hB8;
    bus_write(2'd2, 8'h01); m_seed = 8'h01; m_shift = 8'h01;
    bus_write(2'd3, 8'h01);
    for (int i = 0; i < 20; i++) step(1'b0, "R4 prs output bit");
    bus_write(2'd3, 8'h00);
    peek_shift("R4 prs state");
  endtask

  task automatic t_hold();
    @(negedge clk);
    sin_valid = 1'b1; sin_bit = 1'b1;
    #1 check("R11 ready low when idle", {7'd0, sin_ready}, 8'h00);
    repeat (3) @(negedge clk);
    sin_valid = 1'b0; sin_bit = 1'b0;
    peek_shift("R11 idle hold");
  endtask

  task automatic t_kill();
    bus_write(2'd2, 8'h3C); m_seed = 8'h3C; m_shift = 8'h3C;
    bus_write(2'd3, 8'h01);
    step(1'b1, "R5 sout before kill");
    step(1'b0, "R5 sout before kill");
    @(negedge clk);
    kill = 1'b1; sin_valid = 1'b1; sin_bit = 1'b1;
    #1 check("R6 ready low under kill", {7'd0, sin_ready}, 8'h00);
    @(negedge clk);
    check("R6 reload visible on sout", {7'd0, sout_bit}, {7'd0, m_seed[7]});
    @(negedge clk);
    kill = 1'b0; sin_valid = 1'b0; sin_bit = 1'b0;
    m_shift = m_seed;
    step(1'b1, "R6 first step after kill");
    bus_write(2'd3, 8'h00);
    peek_shift("R6 kill reload then step");
  endtask

  task automatic t_taps_ignored();
    bus_write(2'd1, 8'h07); m_taps = 8'h07;
    bus_write(2'd2, 8'h80); m_seed = 8'h80; m_shift = 8'h80;
    bus_write(2'd3, 8'h01);
    bus_write(2'd1, 8'hFF);
    step(1'b0, "R8 sout");
    step(1'b1, "R8 sout");
    bus_write(2'd3, 8'h00);
    peek_shift("R8 enabled tap write ignored");
    bus_sel = 2'd1; #1 check("R8 taps read zero", bus_rdata, 8'h00);
  endtask

  task automatic t_seed_live();
    bus_write(2'd2, 8'h5A); m_seed = 8'h5A; m_shift = 8'h5A;
    bus_write(2'd3, 8'h01);
    bus_write(2'd2, 8'h11); m_seed = 8'h11;
    #1 check("R9 aux reflects new operand", {7'd0, aux_out}, 8'h00);
    bus_write(2'd3, 8'h00);
    peek_shift("R9 live seed write leaves shift");
  endtask

  task automatic t_compare();
    bus_write(2'd2, 8'h40); m_shift = 8'h40;
    bus_write(2'd3, 8'h01);
    #1 check("R10 eq true", {7'd0, aux_out}, 8'h01);
    bus_write(2'd2, 8'h41);
    #1 check("R10 eq false", {7'd0, aux_out}, 8'h00);
    bus_write(2'd3, 8'h03);
    bus_sel = 2'd3; #1 check("R12 control readback", bus_rdata, 8'h03);
    check("R10 lt true", {7'd0, aux_out}, 8'h01);
    bus_write(2'd2, 8'h40);
    #1 check("R10 lt false when equal", {7'd0, aux_out}, 8'h00);
    bus_write(2'd2, 8'h3F);
    #1 check("R10 lt false when greater", {7'd0, aux_out}, 8'h00);
    bus_sel = 2'd2; #1 check("R12 seed readback", bus_rdata, 8'h3F);
    bus_write(2'd3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_seed_load();
    t_crc();
    t_prs();
    t_hold();
    t_kill();
    t_taps_ignored();
    t_seed_live();
    t_compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule